// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps calendar time in packed BCD: seconds, minutes, hours (24-hour), day of week, date, month, year and century. It holds two copies of the time. The running copy advances on every one-pulse-per-second tick. The user copy is what software reads and writes through a byte-wide register window. When a tick arrives, every field of the incremented running time is copied into the user copy in the same clock edge. A control byte can suspend that copy. One hold bit lets software build a new time in the user copy. Another hold bit freezes a snapshot while the running copy keeps counting.

The window is selected by a 4-bit offset at the top of a memory map. Offsets F to 9 carry year, month, date, day of week, hours, minutes and seconds. Offset 8 is the control byte and offset 1 is the century. Reads are combinational from the user copy and the control byte. Writes take effect at the next clock edge.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, both copies hold century 20, year 00, month 01, date 01, day of week 01 and 00:00:00. The control byte reads 00.
- R2: On each tick the running seconds advance. 59 seconds roll to 00 and carry into minutes, 59 minutes roll to 00 and carry into hours, and hour 23 rolls to 00.
- R3: On a day rollover, the date returns to 01 and the month advances after the last day of the month. Months 04, 06, 09 and 11 have 30 days, and months 01, 03, 05, 07, 08, 10 and 12 have 31.
- R4: February has 29 days when the binary value of the year byte is divisible by 4, and 28 days otherwise.
- R5: A tick at 31/12 23:59:59 gives 01/01 00:00:00. A year of 99 then becomes 00 and the century byte advances by one, wrapping from 99 to 00.
- R6: The day of week counts 1 to 7. It advances only at the midnight rollover, and 7 is followed by 1.
- R7: The user copy changes only on a tick or a user write. On a tick with both hold bits clear, all user time bytes show the new running time from the following cycle on.
- R8: Control bit 7 is the write hold. While it is set, ticks do not update the user copy. A control write that clears bit 7 while it was set loads the whole user copy into the running counters, and that load takes priority over a tick in the same cycle.
- R9: Control bit 6 is the read hold. While it is set, ticks do not update the user copy, but the running counters keep advancing. The first tick after the bit is cleared shows the time including every tick that arrived during the hold.
- R10: Control bits 5:0 store a calibration value. They read back as written and have no effect on counting.
- R11: A user write to a time byte in the same cycle as a transferring tick leaves the written value in that byte. The other bytes take the transferred values.
- R12: Offsets 0 and 2 to 7 read 00, and writes to them change nothing. With the read strobe low, rdata is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_off | input | 4 | Register offset in the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 00 when rd_en is low |

## Verification
Three events can land in the same clock edge: the once-per-second transfer, a user write to a time byte, and the release of the write hold, which loads the counters. The bench drives a tick and a seconds-byte write in the same cycle. It then checks that the written byte survives while the other bytes move to the new time. It also releases the write hold on a tick cycle and expects the loaded value, unincremented, to be the base for the next tick. Expected bytes come from a bench model that tracks the running and user copies separately.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] mins;
        logic [7:0] secs;
    } rtc_time_t;

    typedef struct packed {
        logic       wrap;
        logic [7:0] val;
    } rtc_step_t;

    localparam int OFF_W    = 4;
    localparam int BYTE_W   = 8;
    localparam int WHOLD_B  = 7;
    localparam int RHOLD_B  = 6;

    localparam logic [OFF_W-1:0] OFF_CENT = 4'h1;
    localparam logic [OFF_W-1:0] OFF_CTRL = 4'h8;
    localparam logic [OFF_W-1:0] OFF_SEC  = 4'h9;
    localparam logic [OFF_W-1:0] OFF_MIN  = 4'hA;
    localparam logic [OFF_W-1:0] OFF_HR   = 4'hB;
    localparam logic [OFF_W-1:0] OFF_DOW  = 4'hC;
    localparam logic [OFF_W-1:0] OFF_DATE = 4'hD;
    localparam logic [OFF_W-1:0] OFF_MON  = 4'hE;
    localparam logic [OFF_W-1:0] OFF_YR   = 4'hF;

    localparam rtc_time_t RTC_RESET = '{cent: 8'h20, yr: 8'h00, mon: 8'h01,
                                        date: 8'h01, dow: 8'h01, hr: 8'h00,
                                        mins: 8'h00, secs: 8'h00};

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] t;
        logic [7:0] o;
        t = v / 8'd10;
        o = v % 8'd10;
        return {t[3:0], o[3:0]};
    endfunction

    function automatic logic year_is_leap(input logic [7:0] yr_bcd);
        logic [7:0] b;
        b = bcd_to_bin(yr_bcd);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon_bcd, input logic leap);
        logic [7:0] m;
        m = bcd_to_bin(mon_bcd);
        case (m)
            8'd2:                    return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

    // Advance one BCD field; at or past its last value it returns to first.
    function automatic rtc_step_t bcd_step(input logic [7:0] cur,
                                           input logic [7:0] last,
                                           input logic [7:0] first);
        rtc_step_t r;
        logic [7:0] b;
        b = bcd_to_bin(cur);
        if (b >= last) begin
            r.wrap = 1'b1;
            r.val  = bin_to_bcd(first);
        end else begin
            r.wrap = 1'b0;
            r.val  = bin_to_bcd(b + 8'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur_i,
    output rtc_time_t nxt_o
);
    rtc_step_t s_sec, s_min, s_hr, s_dow, s_date, s_mon, s_yr, s_cent;
    logic      en_min, en_hr, midnight, en_mon, en_yr, en_cent;
    logic [7:0] last_day;

    always_comb begin
        last_day = month_last_day(cur_i.mon, year_is_leap(cur_i.yr));
        s_sec  = bcd_step(cur_i.secs, 8'd59, 8'd0);
        s_min  = bcd_step(cur_i.mins, 8'd59, 8'd0);
        s_hr   = bcd_step(cur_i.hr,   8'd23, 8'd0);
        s_dow  = bcd_step(cur_i.dow,  8'd7,  8'd1);
        s_date = bcd_step(cur_i.date, last_day, 8'd1);
        s_mon  = bcd_step(cur_i.mon,  8'd12, 8'd1);
        s_yr   = bcd_step(cur_i.yr,   8'd99, 8'd0);
        s_cent = bcd_step(cur_i.cent, 8'd99, 8'd0);

        en_min   = s_sec.wrap;
        en_hr    = en_min & s_min.wrap;
        midnight = en_hr & s_hr.wrap;
        en_mon   = midnight & s_date.wrap;
        en_yr    = en_mon & s_mon.wrap;
        en_cent  = en_yr & s_yr.wrap;

        nxt_o      = cur_i;
        nxt_o.secs = s_sec.val;
        if (en_min)   nxt_o.mins = s_min.val;
        if (en_hr)    nxt_o.hr   = s_hr.val;
        if (midnight) nxt_o.dow  = s_dow.val;
        if (midnight) nxt_o.date = s_date.val;
        if (en_mon)   nxt_o.mon  = s_mon.val;
        if (en_yr)    nxt_o.yr   = s_yr.val;
        if (en_cent)  nxt_o.cent = s_cent.val;
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      load_i,
    input  rtc_time_t load_val_i,
    output rtc_time_t cur_o,
    output rtc_time_t nxt_o
);
    rtc_time_t cur_q;

    rtc_advance u_adv (.cur_i(cur_q), .nxt_o(nxt_o));

    always_ff @(posedge clk) begin
        if (rst)         cur_q <= RTC_RESET;
        else if (load_i) cur_q <= load_val_i;
        else if (tick_i) cur_q <= nxt_o;
    end

    assign cur_o = cur_q;

    // R8: a hold release copies the user bytes verbatim
    a_r8_load_copies: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cur_q == $past(load_val_i));

    // R7: no tick, no load, no motion
    a_r7_counter_idle: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(cur_q));

    // R6: day of week moves only when seconds wrap
    a_r6_dow_midnight_only: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && cur_q.secs != 8'h59) |=> $stable(cur_q.dow));

    // R5: year end rolls the year to 00 and moves the century
    a_r5_century_step: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && cur_q.yr == 8'h99 && cur_q.mon == 8'h12 &&
         cur_q.date == 8'h31 && cur_q.hr == 8'h23 && cur_q.mins == 8'h59 &&
         cur_q.secs == 8'h59)
        |=> (cur_q.yr == 8'h00 && cur_q.cent != $past(cur_q.cent)));
endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [OFF_W-1:0]   reg_off,
    input  logic [BYTE_W-1:0]  wdata,
    input  rtc_time_t          nxt_i,
    output logic [BYTE_W-1:0]  rdata,
    output logic               load_o,
    output rtc_time_t          usr_o
);
    rtc_time_t         usr_q, usr_d;
    logic [BYTE_W-1:0] ctrl_q, ctrl_d;
    logic              hold, xfer;

    assign hold = ctrl_q[WHOLD_B] | ctrl_q[RHOLD_B];
    assign xfer = tick_i & ~hold;

    always_comb begin
        usr_d = xfer ? nxt_i : usr_q;
        if (wr_en) begin
            case (reg_off)
                OFF_SEC:  usr_d.secs = wdata;
                OFF_MIN:  usr_d.mins = wdata;
                OFF_HR:   usr_d.hr   = wdata;
                OFF_DOW:  usr_d.dow  = wdata;
                OFF_DATE: usr_d.date = wdata;
                OFF_MON:  usr_d.mon  = wdata;
                OFF_YR:   usr_d.yr   = wdata;
                OFF_CENT: usr_d.cent = wdata;
                default:  ;
            endcase
        end
        ctrl_d = ctrl_q;
        if (wr_en && reg_off == OFF_CTRL) ctrl_d = wdata;
    end

    assign load_o = wr_en && (reg_off == OFF_CTRL) && ctrl_q[WHOLD_B] && !wdata[WHOLD_B];
    assign usr_o  = usr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            usr_q  <= RTC_RESET;
            ctrl_q <= '0;
        end else begin
            usr_q  <= usr_d;
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_off)
                OFF_SEC:  rdata = usr_q.secs;
                OFF_MIN:  rdata = usr_q.mins;
                OFF_HR:   rdata = usr_q.hr;
                OFF_DOW:  rdata = usr_q.dow;
                OFF_DATE: rdata = usr_q.date;
                OFF_MON:  rdata = usr_q.mon;
                OFF_YR:   rdata = usr_q.yr;
                OFF_CENT: rdata = usr_q.cent;
                OFF_CTRL: rdata = ctrl_q;
                default:  rdata = '0;
            endcase
        end
    end

    // R8 R9: any hold bit keeps the user bytes still without a write
    a_r9_hold_freezes_user: assert property (@(posedge clk) disable iff (rst)
        (hold && !wr_en) |=> $stable(usr_q));

    // R7: quiet cycle leaves the user copy alone
    a_r7_quiet_stable: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wr_en) |=> $stable(usr_q));

    // R11: a seconds write wins over a same-cycle transfer
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_off == OFF_SEC) |=> usr_q.secs == $past(wdata));

    // R12: unmapped offsets touch no state
    a_r12_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_off == 4'h3 && !tick_i) |=> ($stable(usr_q) && $stable(ctrl_q)));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_1hz,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  reg_off,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);
    rtc_time_t cur_t, nxt_t, usr_t;
    logic      load;

    rtc_counter u_cnt (
        .clk(clk), .rst(rst), .tick_i(tick_1hz), .load_i(load),
        .load_val_i(usr_t), .cur_o(cur_t), .nxt_o(nxt_t)
    );

    rtc_user_regs u_usr (
        .clk(clk), .rst(rst), .tick_i(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
        .reg_off(reg_off), .wdata(wdata), .nxt_i(nxt_t), .rdata(rdata),
        .load_o(load), .usr_o(usr_t)
    );

    logic unused_cur;
    assign unused_cur = ^cur_t;
endmodule

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int SEED = 1234;

    logic clk = 1'b0, rst = 1'b1, tick_1hz = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] reg_off = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_vec = 0, n_bad = 0;
    logic [63:0] m_int, m_usr;   // byte i: 0 sec,1 min,2 hr,3 dow,4 date,5 mon,6 yr,7 cent
    logic [7:0]  m_ctrl;

    rtc_regfile i_rtc_regfile (.clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .rd_en(rd_en), .reg_off(reg_off), .wdata(wdata), .rdata(rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int v);
        logic [3:0] t, o;
        t = 4'(v / 10); o = 4'(v % 10);
        return {t, o};
    endfunction
    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic logic [3:0] off_of(input int i);
        case (i)
            0: return 4'h9; 1: return 4'hA; 2: return 4'hB; 3: return 4'hC;
            4: return 4'hD; 5: return 4'hE; 6: return 4'hF; default: return 4'h1;
        endcase
    endfunction
    function automatic logic [63:0] pack_t(input int c, yr, mo, d, dw, h, mi, s);
        return {i2b(c), i2b(yr), i2b(mo), i2b(d), i2b(dw), i2b(h), i2b(mi), i2b(s)};
    endfunction
    function automatic logic [63:0] adv(input logic [63:0] v);
        int s, mi, h, dw, d, mo, yr, c;
        s = b2i(v[7:0]); mi = b2i(v[15:8]); h = b2i(v[23:16]); dw = b2i(v[31:24]);
        d = b2i(v[39:32]); mo = b2i(v[47:40]); yr = b2i(v[55:48]); c = b2i(v[63:56]);
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h++;
                if (h == 24) begin
                    h = 0; dw = (dw == 7) ? 1 : dw + 1; d++;
                    if (d > dim(mo, yr)) begin
                        d = 1; mo++;
                        if (mo == 13) begin
                            mo = 1; yr++;
                            if (yr == 100) begin yr = 0; c = (c == 99) ? 0 : c + 1; end
                        end
                    end
                end
            end
        end
        return pack_t(c, yr, mo, d, dw, h, mi, s);
    endfunction

    function automatic int idx_of(input logic [3:0] o);
        for (int i = 0; i < 8; i++) if (off_of(i) == o) return i;
        return -1;
    endfunction

    task automatic model_write(input logic [3:0] o, input logic [7:0] d);
        int k;
        k = idx_of(o);
        if (o == 4'h8) begin
            if (m_ctrl[7] && !d[7]) m_int = m_usr;
            m_ctrl = d;
        end else if (k >= 0) m_usr[k*8 +: 8] = d;
    endtask

    task automatic model_tick();
        m_int = adv(m_int);
        if (m_ctrl[7:6] == 2'b00) m_usr = m_int;
    endtask

    task automatic wr(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; reg_off = o; wdata = d;
        @(negedge clk); wr_en = 1'b0;
        model_write(o, d);
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        model_tick();
    endtask

    task automatic tick_and_write(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk); tick_1hz = 1'b1; wr_en = 1'b1; reg_off = o; wdata = d;
        @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b0;
        if (o == 4'h8) begin
            // load takes priority; old hold state decides the transfer
            if (m_ctrl[7] && !d[7]) begin m_int = m_usr; m_ctrl = d; end
            else begin model_tick(); model_write(o, d); end
        end else begin
            model_tick(); model_write(o, d);
        end
    endtask

    task automatic chk(input logic [3:0] o, input logic [7:0] exp, input string tag);
        @(negedge clk); rd_en = 1'b1; reg_off = o; #1;
        n_vec++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s off=%h actual=%h expected=%h", tag, o, rdata, exp);
        end
        rd_en = 1'b0;
    endtask

    task automatic chk_time(input string tag);
        for (int i = 0; i < 8; i++) chk(off_of(i), m_usr[i*8 +: 8], tag);
    endtask

    task automatic set_time(input logic [63:0] t);
        wr(4'h8, 8'h80);
        for (int i = 0; i < 8; i++) wr(off_of(i), t[i*8 +: 8]);
        wr(4'h8, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(SEED));
        m_int = pack_t(20, 0, 1, 1, 1, 0, 0, 0); m_usr = m_int; m_ctrl = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset contents
        chk_time("R1");
        chk(4'h8, 8'h00, "R1 ctrl");

        // R2 second/minute/hour chain, R7 transfer
        set_time(pack_t(20, 23, 6, 15, 3, 22, 59, 58));
        tick(); chk_time("R2 R7");
        tick(); chk_time("R2 hour carry");

        // R3 30-day month, R6 midnight
        set_time(pack_t(20, 23, 4, 30, 7, 23, 59, 59));
        tick(); chk_time("R3 R6");
        // R3 31-day month
        set_time(pack_t(20, 23, 7, 31, 2, 23, 59, 59));
        tick(); chk_time("R3");

        // R4 non-leap and leap February
        set_time(pack_t(20, 23, 2, 28, 2, 23, 59, 59));
        tick(); chk_time("R4 nonleap");
        set_time(pack_t(20, 24, 2, 28, 3, 23, 59, 59));
        tick(); chk_time("R4 leap 29");
        set_time(pack_t(20, 24, 2, 29, 4, 23, 59, 59));
        tick(); chk_time("R4 leap end");

        // R5 year and century rollover, R6 7 -> 1
        set_time(pack_t(20, 99, 12, 31, 7, 23, 59, 59));
        tick(); chk_time("R5 R6");
        set_time(pack_t(99, 99, 12, 31, 5, 23, 59, 59));
        tick(); chk_time("R5 century wrap");

        // R9 read hold: snapshot frozen while counting continues
        set_time(pack_t(20, 30, 5, 10, 4, 10, 20, 57));
        wr(4'h8, 8'h40);
        tick(); tick(); tick();
        chk_time("R9 frozen");
        wr(4'h8, 8'h00);
        tick(); chk_time("R9 catch up");

        // R8 write hold: ticks blocked, user bytes build new time, release loads
        wr(4'h8, 8'h80);
        tick(); chk_time("R8 held");
        wr(4'h9, 8'h59); wr(4'hA, 8'h59); wr(4'hB, 8'h23);
        tick(); chk_time("R8 edits kept");
        wr(4'h8, 8'h00);
        tick(); chk_time("R8 loaded");
        // R8 release in the same cycle as a tick: load wins
        wr(4'h8, 8'h80); wr(4'h9, 8'h10);
        tick_and_write(4'h8, 8'h00);
        tick(); chk_time("R8 load over tick");

        // R10 calibration bits store and do not disturb counting
        wr(4'h8, 8'h2A); chk(4'h8, 8'h2A, "R10 readback");
        tick(); chk_time("R10 counting");
        wr(4'h8, 8'h00);

        // R11 write collides with a transfer
        tick_and_write(4'h9, 8'h42); chk_time("R11 secs wins");
        tick_and_write(4'hB, 8'h05); chk_time("R11 hours wins");

        // R12 unmapped offsets and idle read strobe
        wr(4'h3, 8'hFF); chk(4'h3, 8'h00, "R12 unmapped");
        wr(4'h0, 8'h5A); chk(4'h0, 8'h00, "R12 off0");
        chk_time("R12 state kept");
        chk(4'h8, 8'h00, "R12 ctrl kept");
        @(negedge clk); rd_en = 1'b0; reg_off = 4'h9; #1;
        n_vec++;
        if (rdata !== 8'h00) begin
            n_bad++; $display("FAIL R12 rd_en low actual=%h expected=00", rdata);
        end

        // Random valid times, biased to end-of-period values
        for (int it = 0; it < 40; it++) begin
            int c, yr, mo, d, dw, h, mi, s, nt;
            c  = 19 + int'($urandom % 3);
            yr = int'($urandom % 100);
            mo = ($urandom % 3 == 0) ? 12 : 1 + int'($urandom % 12);
            d  = ($urandom % 2 == 0) ? dim(mo, yr) : 1 + int'($urandom % dim(mo, yr));
            dw = 1 + int'($urandom % 7);
            h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            s  = 57 + int'($urandom % 3);
            set_time(pack_t(c, yr, mo, d, dw, h, mi, s));
            nt = 1 + int'($urandom % 3);
            for (int k = 0; k < nt; k++) tick();
            chk_time("R2 R3 R4 R5 R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule